// File: doc/BRIEF.md
# Configurable UART Frame Engine

This block is the serial core of an asynchronous port. It turns a byte handed over on a valid/ready pair into a framed bit stream on a single output line. It also recovers bytes from an incoming line. The character shape is selected by a handful of configuration inputs: a short (7-bit) or full (8-bit) data field, an optional extra bit placed after the data, and one or two stop bits. The extra bit is not computed by the block. Software supplies it on transmit, and the receiver reports it as received, which is how 9-bit address marking is carried.

Bit timing comes from a 4-bit rate select. The select picks a divisor, and the divisor sets a 16x oversampling tick. The tick drives both directions. An infrared-style pulse encoding can replace plain NRZ framing on both the transmit and receive sides. A test mode brings the oversampling clock out on a pin and parks the transmit line low. Configuration inputs are taken into an internal active register only while neither direction is inside a character. A change made in the middle of a frame therefore waits for that frame to end.

Top module: `uart_frame_engine`

## Requirements
- R1: After reset, `tx_out` is 1, `tx_ready` is 1, `rx_valid` is 0 and `test_clk` is 0. The active format after reset is 8 data bits, no extra bit, one stop bit, NRZ, and rate select 0.
- R2: An NRZ character is sent as a 0 start bit, then the data bits LSB first (7 when `cfg_seven_bits`=1, otherwise 8), then the stop bit(s) at 1. The line idles at 1. In 7-bit mode the received `rx_data[7]` is 0.
- R3: When `cfg_par_en`=1, one extra bit equal to `tx_par_bit` follows the last data bit. The receiver reports that position on `rx_par_bit`. When `cfg_par_en`=0 no extra bit is sent and `rx_par_bit` is 0.
- R4: With `cfg_two_stop`=1, the transmitter stays busy (`tx_ready`=0) for exactly one more bit time (16 ticks) than with one stop bit.
- R5: The tick period is PRESCALE×D clocks. D = 1<<sel[2:0] when sel[3]=0, and D = 3<<sel[2:0] when sel[3]=1. One bit lasts 16 ticks.
- R6: The receiver starts on a falling line edge and confirms the start bit 8 ticks later. A low pulse that has ended by then yields no character.
- R7: Each later bit is sampled 16 ticks after the previous sample. `rx_valid` pulses for exactly one cycle after the first stop bit is sampled, with `rx_data`, `rx_par_bit` and `rx_frame_err` valid in that cycle.
- R8: If the first stop bit samples 0, `rx_frame_err`=1 is reported with the character. The receiver then waits for the line to return to idle before it looks for a new start bit.
- R9: With `cfg_irda`=1, the transmit line idles at 0. A 0 bit is a high pulse lasting 3 ticks at the start of the bit, and a 1 bit leaves the line low.
- R10: With `cfg_irda`=1, the receiver starts on a rising edge. It reads a bit as 0 when any high level was seen since the previous sample point, and as 1 otherwise.
- R11: Configuration inputs are copied to the active format on the clock after both directions are idle. A change applied during a character does not alter that character; it takes effect from the next character.
- R12: With `test_en`=1, `test_clk` has a period of one tick and is high for the first half of it, and `tx_out` is held at 0. With `test_en`=0, `test_clk` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_seven_bits | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfg_par_en | input | 1 | Adds the software-supplied extra bit after the data |
| cfg_two_stop | input | 1 | 1 sends two stop bits |
| cfg_irda | input | 1 | Selects infrared pulse encoding |
| cfg_baud_sel | input | 4 | Rate select |
| test_en | input | 1 | Test mode: oversample clock out, TX low |
| tx_valid | input | 1 | Transmit request |
| tx_data | input | 8 | Byte to send |
| tx_par_bit | input | 1 | Value of the extra bit to send |
| tx_ready | output | 1 | Transmitter idle; a request is taken when valid and ready |
| tx_out | output | 1 | Serial transmit line |
| rx_in | input | 1 | Serial receive line (asynchronous) |
| rx_valid | output | 1 | One-cycle pulse: character received |
| rx_data | output | 8 | Received data |
| rx_par_bit | output | 1 | Received extra bit |
| rx_frame_err | output | 1 | First stop bit sampled as 0 |
| test_clk | output | 1 | Oversample clock in test mode |

## Verification
The bench loops the transmit line back into the receiver and also drives the receiver from its own serializer, which uses exact bit times at the divide-by-3 rate. Getting the triple-divisor branch wrong would move every sample point and corrupt that byte. A stop bit held low must come back with the error flag. A short low glitch must produce nothing; a receiver that does not confirm at mid-bit would turn the glitch into a phantom character. The bench also switches the format in the middle of a character: a design that applies the change at once would truncate that byte. Other checks measure the interval between the two stop-bit settings, the width of the infrared pulse and the period of the test clock, so that a wrong tick count or pulse length shows up as a number.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;

    // Longest frame: start + 8 data + extra + 2 stop
    localparam int FRAME_MAX = 12;

    typedef struct packed {
        logic       seven;
        logic       par_en;
        logic       two_stop;
        logic       irda;
        logic [3:0] baud_sel;
    } fe_cfg_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_WAIT
    } rx_state_e;

endpackage

// File: rtl/uart_fe_baud.sv
module uart_fe_baud #(
    parameter int PRESCALE = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] sel,
    output logic       tick,
    output logic       half_lvl
);
    localparam int MAX_N = PRESCALE * 384;
    localparam int CW    = $clog2(MAX_N + 1);

    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] div, limit, half;

    always_comb begin
        div      = sel[3] ? (CW'(3) << sel[2:0]) : (CW'(1) << sel[2:0]);
        limit    = div * CW'(PRESCALE) - CW'(1);
        half     = (limit + CW'(1)) >> 1;
        tick     = (cnt_q >= limit);
        half_lvl = (cnt_q < half);
        cnt_d    = tick ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/uart_fe_tx.sv
module uart_fe_tx
    import uart_fe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       seven,
    input  logic       par_en,
    input  logic       two_stop,
    input  logic       irda,
    input  logic       start,
    input  logic [7:0] data,
    input  logic       par,
    output logic       busy,
    output logic       line
);
    typedef struct packed {
        logic                 busy;
        logic [FRAME_MAX-1:0] shreg;
        logic [3:0]           last;
        logic [3:0]           idx;
        logic [3:0]           tcnt;
    } tx_s_t;

    tx_s_t s_q, s_d;
    logic [FRAME_MAX-1:0] frame;
    logic [3:0] nd, total;

    always_comb begin
        s_d   = s_q;
        nd    = seven ? 4'd7 : 4'd8;
        total = 4'd1 + nd + {3'b0, par_en} + (two_stop ? 4'd2 : 4'd1);
        frame    = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (4'(i) < nd) frame[1+i] = data[i];
        end
        if (par_en) frame[nd + 4'd1] = par;

        if (!s_q.busy) begin
            if (start) begin
                s_d.busy  = 1'b1;
                s_d.shreg = frame;
                s_d.last  = total - 4'd1;
                s_d.idx   = '0;
                s_d.tcnt  = '0;
            end
        end else if (tick) begin
            s_d.tcnt = s_q.tcnt + 4'd1;
            if (s_q.tcnt == 4'd15) begin
                if (s_q.idx == s_q.last) begin
                    s_d.busy = 1'b0;
                end else begin
                    s_d.idx   = s_q.idx + 4'd1;
                    s_d.shreg = {1'b1, s_q.shreg[FRAME_MAX-1:1]};
                end
            end
        end

        if (!s_q.busy)  line = !irda;
        else if (irda)  line = !s_q.shreg[0] && (s_q.tcnt < 4'd3);
        else            line = s_q.shreg[0];
        busy = s_q.busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{busy: 1'b0, shreg: '1, last: '0, idx: '0, tcnt: '0};
        else        s_q <= s_d;
    end
endmodule

// File: rtl/uart_fe_rx.sv
module uart_fe_rx
    import uart_fe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       seven,
    input  logic       par_en,
    input  logic       irda,
    input  logic       line,
    output logic       busy,
    output logic       valid,
    output logic [7:0] data,
    output logic       par,
    output logic       ferr
);
    typedef struct packed {
        rx_state_e  st;
        logic       prev;
        logic       pulse;
        logic [3:0] tcnt;
        logic [3:0] idx;
        logic [7:0] data;
        logic       par;
        logic       ferr;
        logic       valid;
    } rx_s_t;

    rx_s_t s_q, s_d;
    logic [3:0] nd, last;
    logic       bitval, level, edge_seen;

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        s_d.prev  = line;
        s_d.pulse = s_q.pulse | line;
        nd        = seven ? 4'd7 : 4'd8;
        last      = nd + {3'b0, par_en} - 4'd1;
        bitval    = irda ? !s_q.pulse : line;
        level     = irda ? !line : line;
        edge_seen = irda ? (line && !s_q.prev) : (!line && s_q.prev);

        unique case (s_q.st)
            RX_IDLE: begin
                s_d.pulse = line;
                if (edge_seen) begin
                    s_d.st   = RX_START;
                    s_d.tcnt = '0;
                end
            end
            RX_START: if (tick) begin
                s_d.tcnt = s_q.tcnt + 4'd1;
                if (s_q.tcnt == 4'd7) begin
                    if (!bitval) begin
                        s_d.st    = RX_DATA;
                        s_d.tcnt  = '0;
                        s_d.idx   = '0;
                        s_d.data  = '0;
                        s_d.par   = 1'b0;
                        s_d.pulse = line;
                    end else begin
                        s_d.st = RX_IDLE;
                    end
                end
            end
            RX_DATA: if (tick) begin
                s_d.tcnt = s_q.tcnt + 4'd1;
                if (s_q.tcnt == 4'd15) begin
                    s_d.pulse = line;
                    if (s_q.idx < nd) s_d.data[s_q.idx[2:0]] = bitval;
                    else              s_d.par = bitval;
                    if (s_q.idx == last) s_d.st  = RX_STOP;
                    else                 s_d.idx = s_q.idx + 4'd1;
                end
            end
            RX_STOP: if (tick) begin
                s_d.tcnt = s_q.tcnt + 4'd1;
                if (s_q.tcnt == 4'd15) begin
                    s_d.pulse = line;
                    s_d.valid = 1'b1;
                    s_d.ferr  = !bitval;
                    s_d.st    = bitval ? RX_IDLE : RX_WAIT;
                end
            end
            RX_WAIT: if (level) s_d.st = RX_IDLE;
            default: s_d.st = RX_IDLE;
        endcase

        busy  = (s_q.st != RX_IDLE);
        valid = s_q.valid;
        data  = s_q.data;
        par   = s_q.par;
        ferr  = s_q.ferr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: RX_IDLE, prev: 1'b1, pulse: 1'b0, tcnt: '0, idx: '0,
                             data: '0, par: 1'b0, ferr: 1'b0, valid: 1'b0};
        else        s_q <= s_d;
    end
endmodule

// File: rtl/uart_frame_engine.sv
module uart_frame_engine
    import uart_fe_pkg::*;
#(
    parameter int PRESCALE = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_seven_bits,
    input  logic       cfg_par_en,
    input  logic       cfg_two_stop,
    input  logic       cfg_irda,
    input  logic [3:0] cfg_baud_sel,
    input  logic       test_en,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    input  logic       tx_par_bit,
    output logic       tx_ready,
    output logic       tx_out,
    input  logic       rx_in,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       rx_par_bit,
    output logic       rx_frame_err,
    output logic       test_clk
);
    typedef struct packed {
        fe_cfg_t cfg;
        logic    sync1;
        logic    sync2;
    } top_s_t;

    top_s_t  s_q, s_d;
    fe_cfg_t cfg_in, cfg_q;
    logic    tick, half_lvl, tx_busy, rx_busy, tx_line;

    always_comb begin
        cfg_in = '{seven: cfg_seven_bits, par_en: cfg_par_en, two_stop: cfg_two_stop,
                   irda: cfg_irda, baud_sel: cfg_baud_sel};
        s_d       = s_q;
        s_d.sync1 = rx_in;
        s_d.sync2 = s_q.sync1;
        if (!tx_busy && !rx_busy) s_d.cfg = cfg_in;
        cfg_q = s_q.cfg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{cfg: '{seven: 1'b0, par_en: 1'b0, two_stop: 1'b0, irda: 1'b0,
                                    baud_sel: 4'd0}, sync1: 1'b1, sync2: 1'b1};
        else        s_q <= s_d;
    end

    uart_fe_baud #(.PRESCALE(PRESCALE)) u_baud (
        .clk(clk), .rst_n(rst_n), .sel(cfg_q.baud_sel), .tick(tick), .half_lvl(half_lvl)
    );

    uart_fe_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .seven(cfg_q.seven), .par_en(cfg_q.par_en), .two_stop(cfg_q.two_stop),
        .irda(cfg_q.irda), .start(tx_valid && !tx_busy), .data(tx_data),
        .par(tx_par_bit), .busy(tx_busy), .line(tx_line)
    );

    uart_fe_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .seven(cfg_q.seven), .par_en(cfg_q.par_en), .irda(cfg_q.irda),
        .line(s_q.sync2), .busy(rx_busy), .valid(rx_valid), .data(rx_data),
        .par(rx_par_bit), .ferr(rx_frame_err)
    );

    assign tx_ready = !tx_busy;
    assign tx_out   = test_en ? 1'b0 : tx_line;
    assign test_clk = test_en && half_lvl;
endmodule

// File: rtl/uart_fe_chk.sv
module uart_fe_chk
    import uart_fe_pkg::*;
(
    input logic    clk,
    input logic    rst_n,
    input logic    tick,
    input logic    tx_ready,
    input logic    tx_out,
    input logic    rx_valid,
    input logic    test_en,
    input logic    test_clk,
    input logic    tx_busy,
    input logic    rx_busy,
    input fe_cfg_t cfg_q
);
    // R7
    rx_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R11
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy || rx_busy) |=> $stable(cfg_q));

    // R12
    test_tx_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        test_en |-> !tx_out);

    // R12
    test_clk_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |-> !test_clk);

    // R9
    irda_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.irda && tx_ready && !test_en) |-> !tx_out);

    // R2
    nrz_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.irda && tx_ready && !test_en) |-> tx_out);

    // R5
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

bind uart_frame_engine uart_fe_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tx_ready(tx_ready), .tx_out(tx_out),
    .rx_valid(rx_valid), .test_en(test_en), .test_clk(test_clk),
    .tx_busy(tx_busy), .rx_busy(rx_busy), .cfg_q(cfg_q)
);

// File: tb/tb_uart_frame_engine.sv
module tb_uart_frame_engine;
    localparam int PRE = 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       c_seven = 1'b0, c_pe = 1'b0, c_two = 1'b0, c_ir = 1'b0;
    logic [3:0] c_sel = 4'd0;
    logic       test_en = 1'b0, tx_valid = 1'b0, tx_par_bit = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_ready, tx_out, rx_in, rx_valid, rx_par_bit, rx_frame_err, test_clk;
    logic [7:0] rx_data;
    logic       loop = 1'b1, bench_rx = 1'b1;

    assign rx_in = loop ? tx_out : bench_rx;

    uart_frame_engine #(.PRESCALE(PRE)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_seven_bits(c_seven), .cfg_par_en(c_pe),
        .cfg_two_stop(c_two), .cfg_irda(c_ir), .cfg_baud_sel(c_sel), .test_en(test_en),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_par_bit(tx_par_bit),
        .tx_ready(tx_ready), .tx_out(tx_out), .rx_in(rx_in), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_par_bit(rx_par_bit), .rx_frame_err(rx_frame_err),
        .test_clk(test_clk)
    );

    typedef struct {
        logic [7:0] d;
        logic       p;
        logic       f;
        string      req;
    } exp_t;

    exp_t q[$];
    exp_t e;
    int checks = 0, fails = 0, got = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, expv);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            got++;
            if (q.size() == 0) begin
                check(0, "R7", "unexpected character", int'(rx_data), 0);
            end else begin
                e = q.pop_front();
                check(rx_data == e.d, e.req, "rx_data", int'(rx_data), int'(e.d));
                check(rx_par_bit == e.p, e.req, "rx_par_bit", int'(rx_par_bit), int'(e.p));
                check(rx_frame_err == e.f, e.req, "rx_frame_err", int'(rx_frame_err), int'(e.f));
            end
        end
    end

    task automatic wait_quiet();
        while (q.size() != 0 || !tx_ready) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    task automatic set_cfg(input logic s7, input logic pe, input logic two,
                           input logic ir, input logic [3:0] sel);
        wait_quiet();
        c_seven = s7; c_pe = pe; c_two = two; c_ir = ir; c_sel = sel;
        repeat (4) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic p, input string req);
        exp_t x;
        x.d = c_seven ? {1'b0, d[6:0]} : d;
        x.p = c_pe ? p : 1'b0;
        x.f = 1'b0;
        x.req = req;
        q.push_back(x);
        while (!tx_ready) @(negedge clk);
        repeat (2) @(negedge clk);
        tx_data = d; tx_par_bit = p; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic expect_rx(input logic [7:0] d, input logic p, input logic f,
                             input string req);
        exp_t x;
        x.d = d; x.p = p; x.f = f; x.req = req;
        q.push_back(x);
    endtask

    task automatic drive_bits(input logic [11:0] bits, input int n, input int bitclk);
        for (int i = 0; i < n; i++) begin
            bench_rx = bits[i];
            repeat (bitclk) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        int d1, d2, w, g0, per, hi;
        bit off_ok;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(tx_out == 1'b1, "R1", "tx_out in reset", int'(tx_out), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_out == 1'b1, "R1", "tx_out", int'(tx_out), 1);
        check(tx_ready == 1'b1, "R1", "tx_ready", int'(tx_ready), 1);
        check(rx_valid == 1'b0, "R1", "rx_valid", int'(rx_valid), 0);
        check(test_clk == 1'b0, "R1", "test_clk", int'(test_clk), 0);

        // R2 R7 plain 8-bit loopback
        set_cfg(0, 0, 0, 0, 4'd0);
        send(8'h55, 0, "R2");
        send(8'hA3, 0, "R2");
        send(8'h00, 0, "R7");
        send(8'hFF, 0, "R7");
        // R2 seven-bit
        set_cfg(1, 0, 0, 0, 4'd0);
        send(8'hFF, 0, "R2");
        send(8'h80, 0, "R2");
        // R3 extra bit
        set_cfg(0, 1, 0, 0, 4'd0);
        send(8'h3C, 1, "R3");
        send(8'hC3, 0, "R3");
        set_cfg(1, 1, 0, 0, 4'd0);
        send(8'h41, 1, "R3");
        set_cfg(0, 0, 0, 0, 4'd0);
        send(8'h9E, 1, "R3");

        // R4 stop-bit duration
        wait_quiet();
        send(8'h55, 0, "R4");
        d1 = 0;
        while (!tx_ready) begin @(negedge clk); d1++; end
        set_cfg(0, 0, 1, 0, 4'd0);
        send(8'h55, 0, "R4");
        d2 = 0;
        while (!tx_ready) begin @(negedge clk); d2++; end
        check((d2 - d1) >= 16 * PRE - PRE && (d2 - d1) <= 16 * PRE + PRE, "R4",
              "two-stop extra busy clocks", d2 - d1, 16 * PRE);

        // R11 change in the middle of a character
        set_cfg(0, 0, 0, 0, 4'd0);
        send(8'hF0, 0, "R11");
        repeat (60) @(negedge clk);
        c_seven = 1'b1;
        send(8'hF0, 0, "R11");

        // R9 R10 infrared pulse mode
        set_cfg(0, 0, 0, 1, 4'd0);
        check(tx_out == 1'b0, "R9", "irda idle level", int'(tx_out), 0);
        send(8'h00, 0, "R10");
        while (tx_out) @(negedge clk);
        while (!tx_out) @(negedge clk);
        w = 0;
        while (tx_out) begin w++; @(negedge clk); end
        check(w == 3 * PRE, "R9", "pulse width clocks", w, 3 * PRE);
        send(8'hA5, 0, "R10");
        send(8'hFF, 0, "R10");

        // R5 bench-driven frame at divide-by-3 (bit = 16*6*PRE/2... = 96 clocks)
        set_cfg(0, 0, 0, 0, 4'd8);
        loop = 1'b0;
        repeat (20) @(negedge clk);
        expect_rx(8'h5A, 0, 0, "R5");
        drive_bits({2'b11, 1'b1, 8'h5A, 1'b0}, 10, 16 * 3 * PRE);
        bench_rx = 1'b1;
        repeat (200) @(negedge clk);

        // R8 framing error, line held low
        expect_rx(8'h33, 0, 1, "R8");
        g0 = got;
        drive_bits({2'b00, 1'b0, 8'h33, 1'b0}, 10, 16 * 3 * PRE);
        bench_rx = 1'b0;
        repeat (1500) @(negedge clk);
        check(got == g0 + 1, "R8", "characters while line low", got - g0, 1);
        bench_rx = 1'b1;
        repeat (300) @(negedge clk);
        expect_rx(8'h81, 0, 0, "R8");
        drive_bits({2'b11, 1'b1, 8'h81, 1'b0}, 10, 16 * 3 * PRE);
        bench_rx = 1'b1;
        repeat (200) @(negedge clk);

        // R6 short low glitch
        g0 = got;
        bench_rx = 1'b0;
        repeat (4 * 3 * PRE) @(negedge clk);
        bench_rx = 1'b1;
        repeat (2000) @(negedge clk);
        check(got == g0, "R6", "characters from glitch", got - g0, 0);

        // R12 test clock at select 9 (tick = 6*PRE clocks)
        set_cfg(0, 0, 0, 0, 4'd9);
        test_en = 1'b1;
        @(negedge clk);
        while (test_clk) @(negedge clk);
        while (!test_clk) @(negedge clk);
        per = 0; hi = 0;
        while (test_clk) begin per++; hi++; @(negedge clk); end
        while (!test_clk) begin per++; @(negedge clk); end
        check(per == 6 * PRE, "R12", "test_clk period", per, 6 * PRE);
        check(hi == 3 * PRE, "R12", "test_clk high time", hi, 3 * PRE);
        check(tx_out == 1'b0, "R12", "tx_out in test mode", int'(tx_out), 0);
        test_en = 1'b0;
        off_ok = 1;
        repeat (40) begin @(negedge clk); if (test_clk) off_ok = 0; end
        check(off_ok, "R12", "test_clk when disabled", int'(!off_ok), 0);

        check(q.size() == 0, "R7", "characters outstanding", q.size(), 0);
        finish_run();
    end
endmodule